// File: doc/BRIEF.md
# Pipelined Composite-Field Byte Substitution

This block computes the AES forward substitution for one byte on every clock cycle. It has no stored 256-entry table. It builds the result from field arithmetic. The input byte is carried by a linear change of basis into a two-level field made of pairs of GF(2^4) elements. There the multiplicative inverse is formed from small 4-bit multiplies, squares and one 4-bit inversion. A second change of basis brings the inverse back to the byte field, and the fixed affine step with constant 0x63 finishes the value. The basis matrices, the extension constant and the root that defines the isomorphism are all computed by constant functions when the design is elaborated.

The `STAGES` parameter sets how much of the arithmetic sits between registers. With 0 the path from input to output is combinational. With 1 a single register cut is placed after the 4-bit inversion. With 3 three cuts are used: after the forward map and norm, after the 4-bit inversion, and after the back map and affine step. A valid flag travels through the same cuts, so the pipeline takes a new byte every cycle and only the latency changes. The house style's state-machine form does not apply here, because the block is a pure datapath with no states or transitions.

Top module: `sbox_pipe`

## Requirements
- R1: For every one of the 256 input bytes, `out_byte` equals the standard AES forward substitution of the byte that entered with the matching `in_vld`, in every `STAGES` setting.
- R2: Input 0x00 yields 0x63, because the inverse of zero is taken as zero before the affine step.
- R3: With `STAGES` = 0, `out_vld` and `out_byte` follow `in_vld` and `in_byte` in the same cycle, with no register on the path.
- R4: With `STAGES` = 1, `out_vld` and `out_byte` show the input one clock edge after it is presented.
- R5: With `STAGES` = 3, `out_vld` and `out_byte` show the input three clock edges after it is presented.
- R6: A new byte can be presented on every cycle. A back-to-back stream of distinct bytes produces one correct result per cycle, in order.
- R7: `out_vld` equals `in_vld` delayed by the latency, including cycles where `in_vld` is low in the middle of a stream. `out_byte` is checked only when `out_vld` is high.
- R8: While `rst_n` is low, every valid bit in the pipeline is cleared at once and `out_vld` is 0. After release, `out_vld` stays 0 until a valid byte has passed through the full latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears only the valid bits |
| in_vld | input | 1 | The input byte is meaningful this cycle |
| in_byte | input | 8 | Byte to substitute |
| out_vld | output | 1 | `in_vld` delayed by the latency (0, 1 or 3 cycles) |
| out_byte | output | 8 | Substituted byte |

## Verification
The assertions look at data only in cycles where the valid bit of the stage beside them is high. This matters because the data registers are never reset, so before the first valid byte they can hold any value. The bench follows this rule: it holds `in_vld` low during reset and compares data only in cycles where the expected output valid is high. The slot assertion compares each registered valid bit with its input from the edge before. Its guard flag becomes 1 only after the first edge out of reset, so the cycles spent in reset never enter that comparison. The bench therefore asserts reset in the middle of a stream to exercise this reset path.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;

    typedef struct packed {
        logic [NIB_W-1:0] hi;
        logic [NIB_W-1:0] lo;
        logic [NIB_W-1:0] norm;
    } front_t;

    typedef struct packed {
        logic [NIB_W-1:0] hi;
        logic [NIB_W-1:0] lo;
        logic [NIB_W-1:0] ninv;
    } mid_t;

    // multiply in GF(2^4) modulo x^4 + x + 1
    function automatic logic [3:0] gf4_mul(input logic [3:0] a, input logic [3:0] b);
        logic [3:0] acc;
        logic [3:0] sh;
        acc = 4'h0;
        sh  = a;
        for (int i = 0; i < 4; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh[3] ? ({sh[2:0], 1'b0} ^ 4'h3) : {sh[2:0], 1'b0};
        end
        return acc;
    endfunction

    // a^14 is the inverse of a for nonzero a; zero maps to zero
    function automatic logic [3:0] gf4_inv(input logic [3:0] a);
        logic [3:0] p2, p4, p8;
        p2 = gf4_mul(a, a);
        p4 = gf4_mul(p2, p2);
        p8 = gf4_mul(p4, p4);
        return gf4_mul(gf4_mul(p2, p4), p8);
    endfunction

    // first constant c making y^2 + y + c irreducible over GF(2^4)
    function automatic logic [3:0] pick_ext_const();
        logic [3:0] c;
        logic       has_root;
        for (int k = 1; k < 16; k++) begin
            c = 4'(k);
            has_root = 1'b0;
            for (int t = 0; t < 16; t++)
                if ((gf4_mul(4'(t), 4'(t)) ^ 4'(t)) == c) has_root = 1'b1;
            if (!has_root) return c;
        end
        return 4'h0;
    endfunction

    localparam logic [3:0] EXT_C = pick_ext_const();

    // multiply in the pair field, element = hi*y + lo
    function automatic logic [7:0] pair_mul(input logic [7:0] a, input logic [7:0] b);
        logic [3:0] hh, hi, lo;
        hh = gf4_mul(a[7:4], b[7:4]);
        hi = hh ^ gf4_mul(a[7:4], b[3:0]) ^ gf4_mul(a[3:0], b[7:4]);
        lo = gf4_mul(hh, EXT_C) ^ gf4_mul(a[3:0], b[3:0]);
        return {hi, lo};
    endfunction

    // an element of the pair field that satisfies x^8+x^4+x^3+x+1
    function automatic logic [7:0] find_root();
        logic [7:0] z, z2, z3, z4, z8;
        for (int k = 2; k < 256; k++) begin
            z  = 8'(k);
            z2 = pair_mul(z, z);
            z3 = pair_mul(z2, z);
            z4 = pair_mul(z2, z2);
            z8 = pair_mul(z4, z4);
            if ((z8 ^ z4 ^ z3 ^ z ^ 8'h01) == 8'h00) return z;
        end
        return 8'h00;
    endfunction

    localparam logic [7:0] ROOT = find_root();

    // column i of the forward basis change is ROOT^i
    function automatic logic [63:0] fwd_columns();
        logic [63:0] cols;
        logic [7:0]  p;
        p = 8'h01;
        for (int i = 0; i < 8; i++) begin
            cols[i*8 +: 8] = p;
            p = pair_mul(p, ROOT);
        end
        return cols;
    endfunction

    localparam logic [63:0] FWD_COLS = fwd_columns();

    function automatic logic [7:0] apply_cols(input logic [7:0] v, input logic [63:0] cols);
        logic [7:0] r;
        r = 8'h00;
        for (int i = 0; i < 8; i++)
            if (v[i]) r = r ^ cols[i*8 +: 8];
        return r;
    endfunction

    // column j of the back map is the byte sent by the forward map to unit vector j
    function automatic logic [63:0] back_columns();
        logic [63:0] cols;
        cols = 64'h0;
        for (int j = 0; j < 8; j++)
            for (int v = 0; v < 256; v++)
                if (apply_cols(8'(v), FWD_COLS) == (8'h01 << j)) cols[j*8 +: 8] = 8'(v);
        return cols;
    endfunction

    localparam logic [63:0] BACK_COLS = back_columns();

    function automatic logic [7:0] affine_63(input logic [7:0] b);
        return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
                 ^ {b[3:0], b[7:4]} ^ 8'h63;
    endfunction

endpackage

// File: rtl/sbox_front.sv
module sbox_front
    import sbox_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    output front_t            fr_out
);
    logic [BYTE_W-1:0] mapped;
    logic [NIB_W-1:0]  h;
    logic [NIB_W-1:0]  l;

    always_comb begin
        mapped = apply_cols(byte_in, FWD_COLS);
        h      = mapped[7:4];
        l      = mapped[3:0];
        fr_out.hi   = h;
        fr_out.lo   = l;
        fr_out.norm = gf4_mul(gf4_mul(h, h), EXT_C) ^ gf4_mul(h, l) ^ gf4_mul(l, l);
    end
endmodule

// File: rtl/sbox_mid.sv
module sbox_mid
    import sbox_pkg::*;
(
    input  front_t fr_in,
    output mid_t   md_out
);
    always_comb begin
        md_out.hi   = fr_in.hi;
        md_out.lo   = fr_in.lo;
        md_out.ninv = gf4_inv(fr_in.norm);
    end
endmodule

// File: rtl/sbox_back.sv
module sbox_back
    import sbox_pkg::*;
(
    input  mid_t              md_in,
    output logic [BYTE_W-1:0] byte_out
);
    logic [BYTE_W-1:0] pair_inv;

    always_comb begin
        pair_inv = {gf4_mul(md_in.hi, md_in.ninv),
                    gf4_mul(md_in.hi ^ md_in.lo, md_in.ninv)};
        byte_out = affine_63(apply_cols(pair_inv, BACK_COLS));
    end
endmodule

// File: rtl/pipe_slot.sv
module pipe_slot #(
    parameter int W      = 8,
    parameter bit ENABLE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] in_dat,
    output logic         out_vld,
    output logic [W-1:0] out_dat
);
    generate
        if (ENABLE) begin : g_reg
            logic live;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    out_vld <= 1'b0;
                    live    <= 1'b0;
                end else begin
                    out_vld <= in_vld;
                    live    <= 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                out_dat <= in_dat;
            end

            // R7
            vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                live |-> (out_vld == $past(in_vld)));
        end else begin : g_wire
            logic unused_ctl;
            assign unused_ctl = clk ^ rst_n;
            assign out_vld    = in_vld;
            assign out_dat    = in_dat;
        end
    endgenerate
endmodule

// File: rtl/sbox_pipe.sv
module sbox_pipe
    import sbox_pkg::*;
#(
    parameter int STAGES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_vld,
    input  logic [7:0] in_byte,
    output logic       out_vld,
    output logic [7:0] out_byte
);
    localparam bit CUT_A   = (STAGES >= 3);
    localparam bit CUT_B   = (STAGES >= 1);
    localparam bit CUT_C   = (STAGES >= 3);
    localparam int FRONT_W = $bits(front_t);
    localparam int MID_W   = $bits(mid_t);

    front_t            fr_comb, fr_reg;
    mid_t              md_comb, md_reg;
    logic [BYTE_W-1:0] bk_comb;
    logic              a_vld, b_vld;

    sbox_front u_front (.byte_in(in_byte), .fr_out(fr_comb));

    pipe_slot #(.W(FRONT_W), .ENABLE(CUT_A)) u_slot_a (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_dat(fr_comb),
        .out_vld(a_vld), .out_dat(fr_reg));

    sbox_mid u_mid (.fr_in(fr_reg), .md_out(md_comb));

    pipe_slot #(.W(MID_W), .ENABLE(CUT_B)) u_slot_b (
        .clk(clk), .rst_n(rst_n), .in_vld(a_vld), .in_dat(md_comb),
        .out_vld(b_vld), .out_dat(md_reg));

    sbox_back u_back (.md_in(md_reg), .byte_out(bk_comb));

    pipe_slot #(.W(BYTE_W), .ENABLE(CUT_C)) u_slot_c (
        .clk(clk), .rst_n(rst_n), .in_vld(b_vld), .in_dat(bk_comb),
        .out_vld(out_vld), .out_dat(out_byte));

    // R1
    nib_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_vld && fr_reg.norm != 4'h0) |-> (gf4_mul(fr_reg.norm, md_comb.ninv) == 4'h1));

    // R2
    zero_to_63_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_vld && md_reg.hi == 4'h0 && md_reg.lo == 4'h0) |-> (bk_comb == 8'h63));

    // R1
    nonzero_not_63_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_vld && {md_reg.hi, md_reg.lo} != 8'h00) |-> (bk_comb != 8'h63));
endmodule

// File: tb/sbox_pipe_bench.sv
module sbox_pipe_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_vld = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       v0, v1, v3;
    logic [7:0] b0, b1, b3;

    int   checks = 0;
    int   fails  = 0;
    logic done   = 1'b0;

    logic [7:0] ref_tab [256];
    logic       hv [4];
    logic [7:0] hb [4];

    localparam logic [15:0] VEC [8] = '{16'h0063, 16'h017c, 16'h53ed, 16'hff16,
                                        16'h10ca, 16'h80cd, 16'h20b7, 16'h0f76};

    always #2 clk = ~clk;

    sbox_pipe #(.STAGES(0)) u_sbox_pipe_s0 (.clk(clk), .rst_n(rst_n), .in_vld(in_vld),
        .in_byte(in_byte), .out_vld(v0), .out_byte(b0));
    sbox_pipe #(.STAGES(1)) u_sbox_pipe_s1 (.clk(clk), .rst_n(rst_n), .in_vld(in_vld),
        .in_byte(in_byte), .out_vld(v1), .out_byte(b1));
    sbox_pipe #(.STAGES(3)) u_sbox_pipe_s3 (.clk(clk), .rst_n(rst_n), .in_vld(in_vld),
        .in_byte(in_byte), .out_vld(v3), .out_byte(b3));

    function automatic logic [7:0] f8_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc, sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh[7] ? ({sh[6:0], 1'b0} ^ 8'h1b) : {sh[6:0], 1'b0};
        end
        return acc;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic compare(input string dreq);
        chk("R3", {7'd0, v0}, {7'd0, hv[0]});
        chk("R4", {7'd0, v1}, {7'd0, hv[1]});
        chk("R5", {7'd0, v3}, {7'd0, hv[3]});
        if (hv[0]) chk(dreq, b0, ref_tab[hb[0]]);
        if (hv[1]) chk(dreq, b1, ref_tab[hb[1]]);
        if (hv[3]) chk(dreq, b3, ref_tab[hb[3]]);
    endtask

    task automatic drive(input logic v, input logic [7:0] b, input string dreq);
        @(negedge clk);
        in_vld  = v;
        in_byte = b;
        for (int k = 3; k > 0; k--) begin
            hv[k] = hv[k-1];
            hb[k] = hb[k-1];
        end
        hv[0] = v;
        hb[0] = b;
        #1;
        compare(dreq);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        in_vld = 1'b0;
        for (int k = 0; k < 4; k++) hv[k] = 1'b0;
        #1;
        // R8: valid bits clear while reset is held
        chk("R8", {7'd0, v0}, 8'h00);
        chk("R8", {7'd0, v1}, 8'h00);
        chk("R8", {7'd0, v3}, 8'h00);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv;
            inv = 8'h00;
            for (int y = 1; y < 256; y++)
                if (f8_mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            ref_tab[x] = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                       ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
        end
        for (int k = 0; k < 4; k++) begin
            hv[k] = 1'b0;
            hb[k] = 8'h00;
        end

        do_reset();
        // R8: nothing valid after release until a byte passes
        for (int k = 0; k < 4; k++) drive(1'b0, 8'h00, "R8");

        // known pairs from the table, back to back
        for (int k = 0; k < 8; k++) begin
            chk(VEC[k][15:8] == 8'h00 ? "R2" : "R1", ref_tab[VEC[k][15:8]], VEC[k][7:0]);
            drive(1'b1, VEC[k][15:8], VEC[k][15:8] == 8'h00 ? "R2" : "R1");
        end
        for (int k = 0; k < 3; k++) drive(1'b0, 8'h00, "R1");

        // R6: every byte in consecutive cycles
        for (int i = 0; i < 256; i++) drive(1'b1, 8'(i), "R6");
        for (int k = 0; k < 3; k++) drive(1'b0, 8'h00, "R6");

        // R7 and R1: full sweep in reversed order with gaps
        for (int i = 0; i < 256; i++) begin
            if (i % 5 == 2) drive(1'b0, 8'hA5, "R7");
            drive(1'b1, 8'(255 - i), "R1");
        end

        // R8: reset in the middle of a valid stream
        for (int k = 0; k < 2; k++) drive(1'b1, 8'(k + 40), "R8");
        do_reset();
        for (int k = 0; k < 2; k++) drive(1'b0, 8'h00, "R8");
        drive(1'b1, 8'h00, "R2");
        for (int k = 0; k < 4; k++) drive(1'b0, 8'h00, "R2");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule